// File: doc/BRIEF.md
# Decode-Stage Issue Interlock for Mixed-Latency Functional Units

This block sits in the decode stage of an in-order pipeline whose execution side has several functional units of different depths: a single-cycle integer ALU, a load path, a pipelined floating-point adder, a pipelined multiplier shared by integer and floating-point work, and one non-pipelined divider. Each cycle it looks at the decoded instruction's unit class, its two source registers, its destination register and the enables for each. It then raises either `issue` or `stall`.

Issue is granted only when four checks all pass. The divider must be free for a new divide. No enabled source may depend on an in-flight result that cannot yet be forwarded. The single register write-back port must be free in the cycle the instruction would write. An earlier writer to the same destination must write strictly before the new one. Completion timing is modelled inside the block only: a per-register countdown scoreboard, a divider occupancy counter and a write-port reservation shift register. Every stall happens in decode.

Top module: `fp_issue_ctl`

## Requirements
- R1: After reset no register is pending, the divider is free and no write slot is reserved, so any first instruction with `dec_valid` high issues.
- R2: The unit class code on `dec_unit` sets the write-back offset W in cycles after issue, where W is the latency plus one. The codes are ALU=0 (W=1), load=1 (W=2), FP add=2 (W=4), multiply=3 (W=7) and divide=4 (W=25). The codes 5 to 7 are treated as ALU.
- R3: An instruction with an enabled source equal to the destination of an instruction issued at cycle t with offset W stalls until cycle t+W and may issue at t+W. A source whose enable is low is never compared.
- R4: A divide issued at cycle t blocks every further divide until cycle t+25. A divide may issue again at t+25.
- R5: An instruction with its destination enable high stalls if an already-issued instruction writes back in the same cycle it would. An instruction with its destination enable low neither checks nor reserves the port.
- R6: A writer to register r stalls while its write-back cycle would not be strictly later than that of a pending earlier writer to r.
- R7: `issue` and `stall` are never high together. Both are low when `dec_valid` is low. With `dec_valid` high, exactly one is high, and `issue` is high only when all of R3 to R6 pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_unit | input | 3 | Unit class code (R2) |
| dec_ra | input | RW (5) | First source register |
| dec_ra_en | input | 1 | First source is read |
| dec_rb | input | RW (5) | Second source register |
| dec_rb_en | input | 1 | Second source is read |
| dec_rd | input | RW (5) | Destination register |
| dec_rd_en | input | 1 | Instruction writes a register |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode this cycle |

## Verification
The bench targets the exact release cycle of each interlock.

- A multiply consumer must stall exactly six cycles. A design off by one releases it early and reads a stale value, or late and costs a cycle.
- A back-to-back divide must wait exactly 24 cycles. A counter loaded with the latency instead of the interval lets two divides overlap.
- An add that lands on a multiply's write cycle must be held, while the same add without a destination must pass. A design that reserves the port for every instruction shows spurious stalls.
- Short-latency writers behind long-latency ones to the same register must wait until their write falls after the earlier one. A design without this check lets the older result overwrite the newer one.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

   typedef enum logic [2:0] {
      UC_ALU  = 3'd0,
      UC_LOAD = 3'd1,
      UC_FADD = 3'd2,
      UC_MUL  = 3'd3,
      UC_DIV  = 3'd4
   } unit_e;

endpackage

// File: rtl/fpi_sb_entry.sv
// One scoreboard slot: remaining cycles until this register's pending write.
module fpi_sb_entry #(
   parameter int OW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [OW-1:0] load_val,
   output logic          pend,
   output logic [OW-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (load) begin
         pend <= 1'b1;
         cnt  <= load_val;
      end else if (pend) begin
         if (cnt == OW'(1)) begin
            pend <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt - OW'(1);
         end
      end
   end

endmodule

// File: rtl/fpi_port_resv.sv
// Write-port reservation: bit k set means the port is taken k cycles from now.
module fpi_port_resv #(
   parameter int DEPTH = 26,
   parameter int OW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             claim,
   input  logic [OW-1:0]    slot,
   output logic             slot_busy,
   output logic [DEPTH-1:0] resv_q
);

   logic [DEPTH-1:0] resv_nxt;

   for (genvar k = 0; k < DEPTH - 1; k++) begin : g_shift
      assign resv_nxt[k] = resv_q[k+1] | (claim && (slot == OW'(k + 1)));
   end
   assign resv_nxt[DEPTH-1] = 1'b0;

   assign slot_busy = resv_q[slot];

   always_ff @(posedge clk) begin
      if (!rst_n) resv_q <= '0;
      else        resv_q <= resv_nxt;
   end

endmodule

// File: rtl/fpi_div_track.sv
// Occupancy of the non-pipelined divider.
module fpi_div_track #(
   parameter int II = 25,
   parameter int CW = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               left_q <= '0;
      else if (start)           left_q <= CW'(II - 1);
      else if (left_q != '0)    left_q <= left_q - CW'(1);
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/fp_issue_ctl.sv
module fp_issue_ctl
   import fpi_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int LAT_ALU  = 0,
   parameter int LAT_LOAD = 1,
   parameter int LAT_FADD = 3,
   parameter int LAT_MUL  = 6,
   parameter int LAT_DIV  = 24,
   parameter int DIV_II   = 25,
   localparam int RW      = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_valid,
   input  logic [2:0]    dec_unit,
   input  logic [RW-1:0] dec_ra,
   input  logic          dec_ra_en,
   input  logic [RW-1:0] dec_rb,
   input  logic          dec_rb_en,
   input  logic [RW-1:0] dec_rd,
   input  logic          dec_rd_en,
   output logic          issue,
   output logic          stall
);

   localparam int MAXW  = LAT_DIV + 1;
   localparam int DEPTH = MAXW + 1;
   localparam int OW    = $clog2(DEPTH);
   localparam int DCW   = $clog2(DIV_II + 1);

   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (LAT_ALU < 0 || LAT_ALU > LAT_LOAD || LAT_LOAD > LAT_DIV ||
       LAT_FADD > LAT_DIV || LAT_MUL > LAT_DIV) begin : g_bad_lat
      $error("divider latency must be the largest and latencies non-negative");
   end
   if (DIV_II < 1) begin : g_bad_ii
      $error("DIV_II must be at least 1");
   end

   unit_e          unit;
   logic [OW-1:0]  wb_off;
   logic [NREG-1:0] sb_pend;
   logic [OW-1:0]  sb_cnt [NREG];
   logic [NREG-1:0] sb_load;
   logic           div_start, div_busy;
   logic           port_claim, port_busy;
   logic [DEPTH-1:0] resv_q;
   logic           raw_a, raw_b, waw_hit, port_hit, div_hit, ok;

   assign unit = unit_e'(dec_unit);

   always_comb begin
      case (unit)
         UC_LOAD: wb_off = OW'(LAT_LOAD + 1);
         UC_FADD: wb_off = OW'(LAT_FADD + 1);
         UC_MUL:  wb_off = OW'(LAT_MUL + 1);
         UC_DIV:  wb_off = OW'(LAT_DIV + 1);
         default: wb_off = OW'(LAT_ALU + 1);
      endcase
   end

   // hazard evaluation
   assign raw_a    = dec_ra_en && sb_pend[dec_ra] && (sb_cnt[dec_ra] > OW'(1));
   assign raw_b    = dec_rb_en && sb_pend[dec_rb] && (sb_cnt[dec_rb] > OW'(1));
   assign waw_hit  = dec_rd_en && sb_pend[dec_rd] && (sb_cnt[dec_rd] > wb_off);
   assign port_hit = dec_rd_en && port_busy;
   assign div_hit  = (unit == UC_DIV) && div_busy;
   assign ok       = !(raw_a || raw_b || waw_hit || port_hit || div_hit);

   assign issue = dec_valid && ok;
   assign stall = dec_valid && !ok;

   assign div_start  = issue && (unit == UC_DIV);
   assign port_claim = issue && dec_rd_en;

   for (genvar r = 0; r < NREG; r++) begin : g_sb
      assign sb_load[r] = port_claim && (dec_rd == RW'(r));
      fpi_sb_entry #(.OW(OW)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (sb_load[r]),
         .load_val (wb_off),
         .pend     (sb_pend[r]),
         .cnt      (sb_cnt[r])
      );
   end

   fpi_port_resv #(.DEPTH(DEPTH), .OW(OW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim     (port_claim),
      .slot      (wb_off),
      .slot_busy (port_busy),
      .resv_q    (resv_q)
   );

   fpi_div_track #(.II(DIV_II), .CW(DCW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .busy  (div_busy)
   );

endmodule

// File: rtl/fpi_checker.sv
module fpi_checker #(
   parameter int DIV_II = 25,
   parameter int DEPTH  = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dec_valid,
   input logic             issue,
   input logic             stall,
   input logic             div_start,
   input logic             div_busy,
   input logic [DEPTH-1:0] resv_q
);

   localparam int GW = $clog2(DIV_II + 1);

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    gap_q <= GW'(DIV_II);
      else if (div_start)            gap_q <= GW'(1);
      else if (gap_q < GW'(DIV_II))  gap_q <= gap_q + GW'(1);
   end

   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue && stall));

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!issue && !stall));

   p_div_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      div_start |-> (gap_q >= GW'(DIV_II)));

   p_div_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (div_start && DIV_II > 1) |=> div_busy);

   p_resv_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resv_q[1] |=> resv_q[0]);

endmodule

bind fp_issue_ctl fpi_checker #(.DIV_II(DIV_II), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dec_valid (dec_valid),
   .issue     (issue),
   .stall     (stall),
   .div_start (div_start),
   .div_busy  (div_busy),
   .resv_q    (resv_q)
);

// File: tb/tb_fp_issue_ctl.sv
module tb_fp_issue_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_valid = 1'b0;
   logic [2:0] dec_unit = '0;
   logic [4:0] dec_ra = '0, dec_rb = '0, dec_rd = '0;
   logic       dec_ra_en = 1'b0, dec_rb_en = 1'b0, dec_rd_en = 1'b0;
   logic       issue, stall;

   int total = 0;
   int bad   = 0;
   longint cyc = 0;

   // reference model state: absolute cycle times
   longint ready_t [32];
   longint wb_t    [32];
   longint div_next = 0;
   bit     port_used [longint];

   fp_issue_ctl dut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
      .dec_ra(dec_ra), .dec_ra_en(dec_ra_en), .dec_rb(dec_rb), .dec_rb_en(dec_rb_en),
      .dec_rd(dec_rd), .dec_rd_en(dec_rd_en), .issue(issue), .stall(stall)
   );

   always #4 clk = ~clk;

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // write-back offset per class code (R2)
   function automatic int wb_of(input logic [2:0] u);
      case (u)
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 7;
         3'd4:    return 25;
         default: return 1;
      endcase
   endfunction

   function automatic bit exp_ok(input longint s, input logic [2:0] u,
                                 input logic [4:0] ra, input bit rae,
                                 input logic [4:0] rb, input bit rbe,
                                 input logic [4:0] rd, input bit rde);
      int w = wb_of(u);
      if (rae && s < ready_t[ra]) return 0;                // R3
      if (rbe && s < ready_t[rb]) return 0;                // R3
      if (u == 3'd4 && s < div_next) return 0;             // R4
      if (rde && port_used.exists(s + w)) return 0;        // R5
      if (rde && (s + w) <= wb_t[rd]) return 0;            // R6
      return 1;
   endfunction

   task automatic chk(input string tag, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, got, exp);
      end
   endtask

   // one decode cycle: drive, compare, advance model
   task automatic step(input bit v, input logic [2:0] u,
                       input logic [4:0] ra, input bit rae,
                       input logic [4:0] rb, input bit rbe,
                       input logic [4:0] rd, input bit rde,
                       input string tag, output bit issued);
      bit e;
      @(negedge clk);
      dec_valid = v; dec_unit = u;
      dec_ra = ra; dec_ra_en = rae; dec_rb = rb; dec_rb_en = rbe;
      dec_rd = rd; dec_rd_en = rde;
      #1;
      e = v && exp_ok(cyc, u, ra, rae, rb, rbe, rd, rde);
      chk({tag, " issue"}, issue, e);
      chk({tag, " stall"}, stall, v && !e);
      issued = e;
      if (e) begin
         int w = wb_of(u);
         if (u == 3'd4) div_next = cyc + 25;
         if (rde) begin
            port_used[cyc + w] = 1'b1;
            ready_t[rd] = cyc + w;
            wb_t[rd] = cyc + w;
         end
      end
      @(posedge clk);
      cyc++;
   endtask

   task automatic idle(input int n);
      bit x;
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R7 idle", x);
   endtask

   // hold one instruction until it issues; return stall count
   task automatic hold(input logic [2:0] u, input logic [4:0] ra, input bit rae,
                       input logic [4:0] rd, input bit rde,
                       input string tag, output int stalls);
      bit x;
      stalls = 0;
      for (int i = 0; i < 60; i++) begin
         step(1, u, ra, rae, 0, 0, rd, rde, tag, x);
         if (x) break;
         stalls++;
      end
   endtask

   initial begin
      bit x;
      int n;
      void'($urandom(32'h1d5e_a7c3));
      for (int r = 0; r < 32; r++) begin
         ready_t[r] = 0;
         wb_t[r] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset issue", issue, 1'b0);
      chk("R1 reset stall", stall, 1'b0);

      // R1: a first divide reading anything issues right away
      step(1, 3'd4, 5'd9, 1, 5'd10, 1, 5'd2, 1, "R1 first", x);
      chk("R1 first issued", x, 1'b1);
      idle(30);

      // R3: multiply consumer stalls for six cycles
      step(1, 3'd3, 0, 0, 0, 0, 5'd1, 1, "R3 producer", x);
      hold(3'd0, 5'd1, 1, 5'd20, 1, "R3 consumer", n);
      chk("R3 mul stall count", n == 6, 1'b1);
      // R3: disabled source is not compared
      step(1, 3'd3, 0, 0, 0, 0, 5'd7, 1, "R3 producer2", x);
      step(1, 3'd0, 5'd7, 0, 0, 0, 5'd21, 1, "R3 disabled src", x);
      chk("R3 disabled src issues", x, 1'b1);
      idle(30);

      // R4: second divide waits 24 cycles
      step(1, 3'd4, 0, 0, 0, 0, 5'd2, 1, "R4 first div", x);
      hold(3'd4, 0, 0, 5'd3, 1, "R4 second div", n);
      chk("R4 div stall count", n == 24, 1'b1);
      idle(30);

      // R5: add landing on multiply write cycle stalls
      step(1, 3'd3, 0, 0, 0, 0, 5'd4, 1, "R5 mul", x);
      idle(2);
      step(1, 3'd2, 0, 0, 0, 0, 5'd5, 1, "R5 clash", x);
      chk("R5 clash stalls", x, 1'b0);
      idle(30);
      // R5: same timing without a destination passes
      step(1, 3'd3, 0, 0, 0, 0, 5'd4, 1, "R5 mul2", x);
      idle(2);
      step(1, 3'd2, 0, 0, 0, 0, 5'd5, 0, "R5 no dest", x);
      chk("R5 no dest issues", x, 1'b1);
      idle(30);

      // R2: load then ALU one cycle later share a write cycle
      step(1, 3'd1, 0, 0, 0, 0, 5'd11, 1, "R2 load", x);
      step(1, 3'd0, 0, 0, 0, 0, 5'd12, 1, "R2 alu", x);
      chk("R2 load/alu clash", x, 1'b0);
      // R2: code 7 behaves as ALU (W=1)
      idle(10);
      step(1, 3'd1, 0, 0, 0, 0, 5'd11, 1, "R2 load2", x);
      step(1, 3'd7, 0, 0, 0, 0, 5'd12, 1, "R2 code7", x);
      chk("R2 code7 as alu", x, 1'b0);
      idle(30);

      // R6: ALU writer behind FP add to the same register
      step(1, 3'd2, 0, 0, 0, 0, 5'd6, 1, "R6 add", x);
      hold(3'd0, 0, 0, 5'd6, 1, "R6 alu", n);
      chk("R6 waw stall count", n == 3, 1'b1);
      idle(30);

      // R7: valid low with a hazard gives neither output
      step(1, 3'd3, 0, 0, 0, 0, 5'd8, 1, "R7 mul", x);
      step(0, 3'd0, 5'd8, 1, 0, 0, 5'd8, 1, "R7 invalid", x);
      chk("R7 invalid no stall", stall, 1'b0);
      idle(30);

      // R7: constrained random mix on a few registers
      for (int i = 0; i < 6000; i++) begin
         int      p = $urandom_range(0, 99);
         logic [2:0] u;
         if      (p < 40) u = 3'd0;
         else if (p < 60) u = 3'd1;
         else if (p < 75) u = 3'd2;
         else if (p < 90) u = 3'd3;
         else if (p < 97) u = 3'd4;
         else             u = 3'($urandom_range(5, 7));
         step($urandom_range(0, 99) < 85, u,
              5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              5'($urandom_range(0, 3)), $urandom_range(0, 9) < 8,
              "R7 random", x);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule